// File: doc/BRIEF.md
# SPI Memory Status and Write-Protect Unit

This block is the status register and write-protection logic of a small serial memory on an SPI bus. It watches chip select, serial clock and serial data in, and it samples a write-protect pin and an internal-busy flag. It decodes five instructions: write-enable, write-disable, read-status, write-status and data-write. It holds the status bits, returns them on the serial output, and decides whether each status write and each data write is accepted. The array beside it asks through `chk_addr_i` whether a byte may be written now, and it receives a one-cycle `commit_o` pulse when a data-write instruction is accepted at deselect.

All pins are sampled on `clk_i`, which must run at least four times faster than the serial clock. The pins are assumed to be already synchronous to `clk_i`. Instructions take effect on the `clk_i` edge where chip select is seen to rise, and only if the frame held whole bytes. A sticky disable bit in the status byte works with the live protect pin to give two protection levels. Under software protection, the block-protect bits only guard part of the array. Under hardware protection, the status byte is frozen as well. The protect pin must be pulled low on the board so that a floating pin means "protect".

Top module: `spi_wp_status`

## Requirements
- R1: Only serial clock idle levels low (mode 0) and high (mode 3) are supported. Data in is sampled on the rising serial clock edge, MSB first. After the read-status opcode 0x05, every further byte shifted out is the current status byte, MSB first, changing on falling edges. The output is 0 at all other times.
- R2: The status byte is laid out as follows: bit 0 is write-in-progress (follows `busy_i`), bit 1 is the write-enable latch, bit 2 is BP0, bit 3 is BP1, bit 7 is the status-write-disable bit, and bits 6:4 read 0. After reset the status byte is 0x00.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each acts only when chip select rises after exactly 8 clock bits. A frame of 7 or 9 bits has no effect.
- R4: Write-status (0x01 followed by exactly one data byte) is accepted while the disable bit is 0 and the latch is set, whatever the protect pin level. It loads bits 7, 3 and 2 from the data byte. A frame with any other length has no effect.
- R5: While the disable bit is 1 and `wp_i` is low, every write-status is ignored, and the write-enable latch keeps its value.
- R6: While the disable bit is 1 and `wp_i` is high, write-status is accepted when the latch is set.
- R7: Hardware protection is entered in either of two ways: by setting the disable bit while the pin is already low, or by lowering the pin after the bit was set. Raising the pin is the only way to leave it.
- R8: A write-status never loads bits 1:0 or bits 6:4 from its data byte. An accepted write-status clears the latch. Without the latch set, a write-status has no effect.
- R9: With a 1024-byte array, block-protect codes 00, 01, 10 and 11 lock no addresses, addresses 768 to 1023, addresses 512 to 1023 and all addresses respectively. `wr_permit_o` is high exactly when the latch is set, `busy_i` is low and `chk_addr_i` is not locked.
- R10: Data-write is opcode 0x02, then two address bytes (the low 10 bits are the address), then at least one data byte, in whole bytes. It is accepted when the latch is set, `busy_i` is low and the address is not locked. On acceptance `commit_o` pulses for one cycle after chip select rises and the latch clears. Otherwise there is no pulse and the latch is unchanged.
- R11: While `busy_i` is high, every instruction except read-status has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| wp_i | input | 1 | Write-protect pin, low protects |
| busy_i | input | 1 | Internal program cycle running |
| chk_addr_i | input | 10 | Array address being queried |
| miso_o | output | 1 | Serial data out |
| wr_permit_o | output | 1 | Write to `chk_addr_i` allowed now |
| commit_o | output | 1 | Accepted data-write, one cycle |

## Verification
The hardest state to reach is hardware protection. Getting there needs a write-enable and a write-status while the pin is high, then a pin change, then a second write-enable and write-status pair. The bench reaches it for every combination of disable bit, pin level, block-protect code and clock mode. It first loads the status through the pin-high path and then attempts an inverting write-status. A directed sequence also enters protection in both orders and leaves it by raising the pin.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // region locked by the block-protect code, from the two top address bits
  function automatic logic blk_locked(input logic [1:0] bp, input logic [1:0] msb2);
    unique case (bp)
      2'b00:   return 1'b0;
      2'b01:   return msb2 == 2'b11;
      2'b10:   return msb2[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_wp_link.sv
module spi_wp_link #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  input  logic [7:0]       tx_byte_i,
  input  logic             tx_en_i,
  output logic             miso_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             frame_end_o,
  output logic             aligned_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sclk_q, csn_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       rx_q;
  logic [7:0]       tx_q;
  logic             rise, fall;

  assign rise        = sclk_i & ~sclk_q & ~csn_i;
  assign fall        = ~sclk_i & sclk_q & ~csn_i;
  assign frame_end_o = csn_i & ~csn_q;
  assign aligned_o   = (bit_q == 3'd0);
  assign byte_cnt_o  = cnt_q;
  assign byte_vld_o  = rise && (bit_q == 3'd7);
  assign byte_o      = {rx_q, mosi_i};
  assign miso_o      = tx_en_i & tx_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      bit_q  <= '0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      csn_q  <= csn_i;
      if (csn_i) begin
        bit_q <= '0;
        cnt_q <= '0;
      end else if (rise) begin
        rx_q  <= {rx_q[5:0], mosi_i};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7 && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      // reload at byte boundary so repeated reads stream fresh status
      if (fall) tx_q <= (bit_q == 3'd0) ? tx_byte_i : {tx_q[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              frame_end_i,
  input  logic              aligned_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [7:0]        stat_o,
  output logic              tx_en_o,
  output logic              wr_permit_o,
  output logic              commit_o
);
  localparam logic [CNT_W-1:0] N_CMD  = CNT_W'(1);
  localparam logic [CNT_W-1:0] N_WRSR = CNT_W'(2);
  localparam logic [CNT_W-1:0] N_WR   = CNT_W'(4);

  logic [7:0]  opc_q;
  logic [15:0] addr_q;
  logic        srwd_q, wel_q, new_srwd_q, commit_q;
  logic [1:0]  bp_q, new_bp_q;
  logic        sr_open, addr_locked, chk_locked;
  logic        unused_addr_bits;

  assign sr_open     = ~srwd_q | wp_i;
  assign addr_locked = blk_locked(bp_q, addr_q[ADDR_W-1 -: 2]);
  assign chk_locked  = blk_locked(bp_q, chk_addr_i[ADDR_W-1 -: 2]);
  assign unused_addr_bits = ^{addr_q[15:ADDR_W], addr_q[ADDR_W-3:0], chk_addr_i[ADDR_W-3:0]};

  assign stat_o      = {srwd_q, 3'b000, bp_q, wel_q, busy_i};
  assign tx_en_o     = (opc_q == OP_RDSR) && (byte_cnt_i != '0);
  assign wr_permit_o = wel_q & ~busy_i & ~chk_locked;
  assign commit_o    = commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q      <= '0;
      addr_q     <= '0;
      srwd_q     <= 1'b0;
      wel_q      <= 1'b0;
      bp_q       <= '0;
      new_srwd_q <= 1'b0;
      new_bp_q   <= '0;
      commit_q   <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (byte_vld_i) begin
        if (byte_cnt_i == '0) opc_q <= byte_i;
        if (byte_cnt_i == N_CMD) begin
          new_srwd_q <= byte_i[7];
          new_bp_q   <= byte_i[3:2];
        end
        if (byte_cnt_i == N_CMD || byte_cnt_i == N_WRSR) addr_q <= {addr_q[7:0], byte_i};
      end
      if (frame_end_i && aligned_i && !busy_i) begin
        unique case (opc_q)
          OP_WREN: if (byte_cnt_i == N_CMD) wel_q <= 1'b1;
          OP_WRDI: if (byte_cnt_i == N_CMD) wel_q <= 1'b0;
          OP_WRSR: if (byte_cnt_i == N_WRSR && wel_q && sr_open) begin
            srwd_q <= new_srwd_q;
            bp_q   <= new_bp_q;
            wel_q  <= 1'b0;
          end
          OP_WRITE: if (byte_cnt_i >= N_WR && wel_q && !addr_locked) begin
            commit_q <= 1'b1;
            wel_q    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_wp_status.sv
module spi_wp_status #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              miso_o,
  output logic              wr_permit_o,
  output logic              commit_o
);
  localparam int CNT_W = 3;

  logic             byte_vld, frame_end, aligned, tx_en;
  logic [7:0]       rx_byte, stat;
  logic [CNT_W-1:0] byte_cnt;

  spi_wp_link #(.CNT_W(CNT_W)) u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .csn_i       (csn_i),
    .mosi_i      (mosi_i),
    .tx_byte_i   (stat),
    .tx_en_i     (tx_en),
    .miso_o      (miso_o),
    .byte_vld_o  (byte_vld),
    .byte_o      (rx_byte),
    .byte_cnt_o  (byte_cnt),
    .frame_end_o (frame_end),
    .aligned_o   (aligned)
  );

  spi_wp_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld),
    .byte_i      (rx_byte),
    .byte_cnt_i  (byte_cnt),
    .frame_end_i (frame_end),
    .aligned_i   (aligned),
    .wp_i        (wp_i),
    .busy_i      (busy_i),
    .chk_addr_i  (chk_addr_i),
    .stat_o      (stat),
    .tx_en_o     (tx_en),
    .wr_permit_o (wr_permit_o),
    .commit_o    (commit_o)
  );
endmodule

// File: rtl/spi_wp_status_chk.sv
module spi_wp_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_i,
  input logic       busy_i,
  input logic [7:0] stat_i,
  input logic       frame_end_i,
  input logic       commit_i,
  input logic       permit_i
);
  // R5
  hpm_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && stat_i[7] && !wp_i) |=> ({stat_i[7], stat_i[3:2]} == $past({stat_i[7], stat_i[3:2]})));
  // R3
  wel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[1]) |-> $past(frame_end_i));
  // R10
  commit_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (!stat_i[1] && $past(frame_end_i)));
  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && busy_i) |=> ($stable(stat_i[7:1]) && !commit_i));
  // R9
  full_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[3:2] == 2'b11) |-> !permit_i);
endmodule

bind spi_wp_status spi_wp_status_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wp_i        (wp_i),
  .busy_i      (busy_i),
  .stat_i      (stat),
  .frame_end_i (frame_end),
  .commit_i    (commit_o),
  .permit_i    (wr_permit_o)
);

// File: tb/spi_wp_status_test.sv
module spi_wp_status_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, wp = 1'b1, busy = 1'b0;
  logic [9:0] chk_addr = '0;
  logic miso, permit, commit;
  logic mode3 = 1'b0;
  int n_chk = 0, n_fail = 0, n_commit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wp_status uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .wp_i(wp), .busy_i(busy), .chk_addr_i(chk_addr),
    .miso_o(miso), .wr_permit_o(permit), .commit_o(commit)
  );

  always @(negedge clk) if (commit) n_commit++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] d, input int nb, output logic [31:0] r);
    r = '0;
    sclk = mode3;
    repeat (2) @(negedge clk);
    csn = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0;
      mosi = d[31-i];
      repeat (2) @(negedge clk);
      r = {r[30:0], miso};
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    if (!mode3) sclk = 1'b0;
    repeat (2) @(negedge clk);
    csn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [31:0] r;
    xfer({op, 24'h0}, 8, r);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [31:0] r;
    xfer({8'h01, v, 16'h0}, 16, r);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [31:0] r;
    xfer({8'h05, 24'h0}, 16, r);
    s = r[7:0];
  endtask

  function automatic logic locked(input logic [1:0] bp, input int a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a >= 768;
      2'd2: return a >= 512;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 reset value, R1 output idle during opcode
    xfer({8'h05, 24'h0}, 16, r);
    check("R2 reset status", r[7:0], 8'h00);
    check("R1 miso low during opcode", r[15:8], 8'h00);
    check("R9 no permit after reset", permit, 1'b0);

    // R3 latch set/clear and partial frames
    xfer({8'h06, 24'h0}, 7, r); rdsr(s);
    check("R3 7-bit wren ignored", s, 8'h00);
    xfer({8'h06, 24'h0}, 9, r); rdsr(s);
    check("R3 9-bit wren ignored", s, 8'h00);
    cmd(8'h06); rdsr(s);
    check("R3 wren sets latch", s, 8'h02);
    cmd(8'h04); rdsr(s);
    check("R3 wrdi clears latch", s, 8'h00);

    // R8 write-status without latch
    wrsr(8'h8C); rdsr(s);
    check("R8 wrsr without latch ignored", s, 8'h00);
    // R4 wrong frame length
    cmd(8'h06);
    xfer({8'h01, 8'h0C, 8'h00, 8'h00}, 24, r); rdsr(s);
    check("R4 3-byte wrsr ignored", s, 8'h02);
    cmd(8'h04);

    // R4 R5 R6 R8 R9 R1: sweep mode, disable bit, pin, protect code
    for (int m = 0; m < 2; m++)
      for (int sd = 0; sd < 2; sd++)
        for (int w = 0; w < 2; w++)
          for (int b = 0; b < 4; b++) begin
            logic [7:0] base, nv, ex;
            logic acc;
            int bad;
            mode3 = m[0];
            base = {sd[0], 3'b000, b[1:0], 2'b00};
            wp = 1'b1;
            cmd(8'h06); wrsr(base); rdsr(s);
            check("R4 load through pin-high path", s, base);
            wp = w[0];
            cmd(8'h06); rdsr(s);
            check("R2 latch bit position", s, base | 8'h02);
            bad = 0;
            for (int a = 0; a < 1024; a++) begin
              chk_addr = a[9:0];
              #1;
              if (permit !== !locked(b[1:0], a)) bad++;
            end
            check("R9 permit sweep mismatches", bad, 0);
            nv = {~sd[0], 3'b111, ~b[1:0], 2'b11};
            wrsr(nv); rdsr(s);
            acc = !(sd[0] && !w[0]);
            ex = acc ? {~sd[0], 3'b000, ~b[1:0], 2'b00} : (base | 8'h02);
            if (sd == 0) check("R4 R8 accepted with bit clear", s, ex);
            else if (w != 0) check("R6 accepted with pin high", s, ex);
            else check("R5 ignored in protected mode", s, ex);
            wp = 1'b1;
            cmd(8'h06); wrsr(8'h00);
          end
    mode3 = 1'b0;
    rdsr(s);
    check("R4 sweep cleanup", s, 8'h00);

    // R7 pin low first, then set bit
    wp = 1'b0;
    cmd(8'h06); wrsr(8'h80); rdsr(s);
    check("R7 bit set while pin low", s, 8'h80);
    cmd(8'h06); wrsr(8'h8C); rdsr(s);
    check("R7 protected after pin-then-bit", s, 8'h82);
    wp = 1'b1;
    wrsr(8'h8C); rdsr(s);
    check("R7 raising pin leaves protection", s, 8'h8C);
    // bit set first, then pin low
    wp = 1'b0;
    cmd(8'h06); wrsr(8'h00); rdsr(s);
    check("R7 protected after bit-then-pin", s, 8'h8E);
    wp = 1'b1;
    wrsr(8'h00); rdsr(s);
    check("R7 left by pin high", s, 8'h00);

    // R11 busy
    busy = 1'b1;
    rdsr(s);
    check("R11 R2 busy shows in bit 0", s, 8'h01);
    cmd(8'h06);
    busy = 1'b0; rdsr(s);
    check("R11 wren ignored while busy", s, 8'h00);
    cmd(8'h06);
    busy = 1'b1;
    chk_addr = 10'd0; #1;
    check("R9 R11 no permit while busy", permit, 1'b0);
    wrsr(8'h0C);
    busy = 1'b0; rdsr(s);
    check("R11 wrsr ignored while busy", s, 8'h02);

    // R10 data write, upper quarter locked
    wrsr(8'h04); cmd(8'h06); rdsr(s);
    check("R10 setup", s, 8'h06);
    begin
      int c0;
      c0 = n_commit;
      xfer({8'h02, 16'h03FF, 8'hA5}, 32, r); rdsr(s);
      check("R10 locked address no commit", n_commit - c0, 0);
      check("R10 locked address keeps latch", s, 8'h06);
      xfer({8'h02, 16'h02FF, 8'h00}, 24, r); rdsr(s);
      check("R10 no data byte no commit", n_commit - c0, 0);
      xfer({8'h02, 16'h02FF, 8'h5A}, 31, r); rdsr(s);
      check("R10 partial byte no commit", n_commit - c0, 0);
      xfer({8'h02, 16'h02FF, 8'h5A}, 32, r); rdsr(s);
      check("R10 open address commits once", n_commit - c0, 1);
      check("R10 commit clears latch", s, 8'h04);
      xfer({8'h02, 16'h0000, 8'h5A}, 32, r);
      check("R10 no commit without latch", n_commit - c0, 1);
    end

    // R1 streamed status in mode 3
    mode3 = 1'b1;
    xfer({8'h05, 24'h0}, 32, r);
    check("R1 repeated status bytes", r[23:0], 24'h040404);
    mode3 = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule